// File: doc/BRIEF.md
# Programmable-Rate Timer Channel

This block is one 16-bit timer channel. An 8-bit control register chooses three things: where count events come from, which edge of that source counts, and what clears the counter. There are seven internal rates taken from a free-running prescaler, plus an external pin. Four compare registers, A to D, are watched for equality with the counter. Any one of them can be chosen to return the counter to zero.

A channel can also follow a shared clear line driven by other channels, so that a group of channels restarts together. Whenever this channel clears itself on a compare match, it drives a one-cycle clear request for its neighbours.

Registers C and D can be marked as buffers by two plain inputs. A register marked this way neither raises a match nor clears the counter.

Top module: `tmr_channel`

## Requirements
- R1: While reset is held, the counter, the control register, the match strobes and the clear request all read zero.
- R2: A write pulse loads the control byte, which reads back on `ctrl_o` one clock edge later. Its fields are: bits 7:5 clear select, bits 4:3 edge select, bits 2:0 source select.
- R3: Source code 000 advances the counter on every clock edge, whatever the edge select holds.
- R4: Source codes 001, 010, 011, 101, 110 and 111 divide the clock by 4, 16, 64, 1024, 256 and 4096. Take a free-running count p of clock edges since reset. For divider N, the rising event falls on the edge where p mod N equals N/2-1, and the falling event on the edge where p mod N equals N-1. So any N consecutive edges hold exactly one of each.
- R5: Edge code 00 counts rising events, 01 counts falling events, and any code with bit 4 set counts both.
- R6: Source code 100 counts edges of `ext_clk_i`, filtered by the edge select. The pin passes through two synchronizing flops, so the counter moves on the third clock edge after the pin changes.
- R7: Clear codes 001, 010, 101 and 110 select register A, B, C and D. On a count event where the counter equals the selected register, the counter becomes 0 instead of incrementing. Codes 000 and 100 never clear, and the counter wraps from 0xFFFF to 0.
- R8: Clear codes 011 and 111 zero the counter on any edge where `sync_clr_i` is high, with or without a count event. Under any other clear code, `sync_clr_i` is ignored.
- R9: `match_o` bit i (0 = A, 1 = B, 2 = C, 3 = D) is high for one cycle after a count event at which the counter equals register i.
- R10: While `buf_c_i` (or `buf_d_i`) is high, register C (or D) gives no match strobe and does not clear the counter, even when it is the selected clear source.
- R11: `clr_req_o` is high for the one cycle after a count event that cleared the counter on its own compare match. It rises on the same edge as the counter's return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control byte to write |
| ctrl_o | output | 8 | Current control byte |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| sync_clr_i | input | 1 | Clear from other channels in the group |
| cmp_a_i | input | 16 | Compare register A |
| cmp_b_i | input | 16 | Compare register B |
| cmp_c_i | input | 16 | Compare register C |
| cmp_d_i | input | 16 | Compare register D |
| buf_c_i | input | 1 | Register C used as a buffer |
| buf_d_i | input | 1 | Register D used as a buffer |
| cnt_o | output | 16 | Counter value |
| match_o | output | 4 | Compare match strobes, bit 0 = A |
| clr_req_o | output | 1 | Clear request to other channels |

## Verification
A count event changes the counter on the same edge that detects it. The match strobes and the clear request are registered alongside, so all three are read one edge after the event. A control write is visible one edge later. A pin change moves the counter three edges later, and a sync clear takes effect on the next edge. The bench drives inputs and samples outputs on the falling clock edge, against a cycle-exact model that steps on each rising edge. Independent arithmetic checks count events over whole divider periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CMP = 4;
    localparam int NUM_SRC = 8;
    localparam int CTRL_W  = 8;
    localparam logic [2:0] SRC_FULL = 3'd0;
    localparam logic [2:0] SRC_PIN  = 3'd4;

    // Field order is fixed: bits 7:5 clear select, 4:3 edge, 2:0 source.
    typedef struct packed {
        logic [2:0] clr_sel;
        logic [1:0] edge_sel;
        logic [2:0] src_sel;
    } ctrl_t;

    // log2 of the internal divide ratio; 0 means "not an internal divider".
    function automatic int src_shift(logic [2:0] sel);
        case (sel)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd5:    return 10;
            3'd6:    return 8;
            3'd7:    return 12;
            default: return 0;
        endcase
    endfunction

    function automatic logic is_group_clear(logic [2:0] sel);
        return sel[1:0] == 2'b11;
    endfunction

    // One-hot selection of the compare register that may clear the counter.
    function automatic logic [NUM_CMP-1:0] clr_select(logic [2:0] sel);
        case (sel)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0010;
            3'd5:    return 4'b0100;
            3'd6:    return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int HIST_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [HIST_W-1:0] pipe;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[HIST_W-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o = s_q.pipe[HIST_W-2] & ~s_q.pipe[HIST_W-1];
    assign fall_o = ~s_q.pipe[HIST_W-2] & s_q.pipe[HIST_W-1];

    // R6: a detected pin edge is a single-cycle event
    p_pin_edge_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler import tmr_pkg::*; #(
    parameter int PSC_W = 12
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] src_sel_i,
    input  logic [1:0] edge_sel_i,
    input  logic       pin_rise_i,
    input  logic       pin_fall_i,
    output logic       tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] div;
    } psc_state_t;

    psc_state_t s_d, s_q;
    logic [NUM_SRC-1:0] rise_v;
    logic [NUM_SRC-1:0] fall_v;

    always_comb begin
        s_d     = s_q;
        s_d.div = s_q.div + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int SH = src_shift(3'(g));
        if (g == int'(SRC_PIN)) begin : g_pin
            assign rise_v[g] = pin_rise_i;
            assign fall_v[g] = pin_fall_i;
        end else if (SH == 0) begin : g_full
            assign rise_v[g] = 1'b1;
            assign fall_v[g] = 1'b1;
        end else begin : g_div
            assign rise_v[g] = (s_q.div[SH-1:0] == SH'((1 << (SH-1)) - 1));
            assign fall_v[g] = &s_q.div[SH-1:0];
        end
    end

    always_comb begin
        if (src_sel_i == SRC_FULL)  tick_o = 1'b1;
        else if (edge_sel_i[1])     tick_o = rise_v[src_sel_i] | fall_v[src_sel_i];
        else if (edge_sel_i[0])     tick_o = fall_v[src_sel_i];
        else                        tick_o = rise_v[src_sel_i];
    end

    // R4: divided sources never produce events on two adjacent edges
    p_div_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && src_sel_i != SRC_FULL && src_sel_i != SRC_PIN)
        |=> (!tick_o || src_sel_i != $past(src_sel_i)));

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CNT_W = 16,
    parameter int NUM   = 4
) (
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic [NUM-1:0][CNT_W-1:0] ref_i,
    input  logic [NUM-1:0]            mute_i,
    output logic [NUM-1:0]            hit_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit_o[g] = ~mute_i[g] & (cnt_i == ref_i[g]);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctrl_we_i,
    input  logic [7:0]       ctrl_wdata_i,
    output logic [7:0]       ctrl_o,
    input  logic             ext_clk_i,
    input  logic             sync_clr_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic [CNT_W-1:0] cmp_c_i,
    input  logic [CNT_W-1:0] cmp_d_i,
    input  logic             buf_c_i,
    input  logic             buf_d_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [3:0]       match_o,
    output logic             clr_req_o
);
    typedef struct packed {
        ctrl_t              ctrl;
        logic [CNT_W-1:0]   cnt;
        logic [NUM_CMP-1:0] match;
        logic               clr;
    } chan_state_t;

    chan_state_t s_d, s_q;

    logic pin_rise, pin_fall, tick;
    logic [NUM_CMP-1:0] hit;
    logic [NUM_CMP-1:0] mute;
    logic [NUM_CMP-1:0][CNT_W-1:0] refs;
    logic sel_hit, group_clr;

    tmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_clk_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_sel_i  (s_q.ctrl.src_sel),
        .edge_sel_i (s_q.ctrl.edge_sel),
        .pin_rise_i (pin_rise),
        .pin_fall_i (pin_fall),
        .tick_o     (tick)
    );

    assign refs = {cmp_d_i, cmp_c_i, cmp_b_i, cmp_a_i};
    assign mute = {buf_d_i, buf_c_i, 2'b00};

    tmr_compare #(.CNT_W(CNT_W), .NUM(NUM_CMP)) u_cmp (
        .cnt_i  (s_q.cnt),
        .ref_i  (refs),
        .mute_i (mute),
        .hit_o  (hit)
    );

    always_comb begin
        sel_hit   = |(hit & clr_select(s_q.ctrl.clr_sel));
        group_clr = is_group_clear(s_q.ctrl.clr_sel) & sync_clr_i;

        s_d       = s_q;
        s_d.match = '0;
        s_d.clr   = 1'b0;
        if (ctrl_we_i) s_d.ctrl = ctrl_t'(ctrl_wdata_i);

        if (group_clr)  s_d.cnt = '0;
        else if (tick)  s_d.cnt = sel_hit ? '0 : s_q.cnt + 1'b1;

        if (tick) begin
            s_d.match = hit;
            s_d.clr   = sel_hit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ctrl_o    = s_q.ctrl;
    assign cnt_o     = s_q.cnt;
    assign match_o   = s_q.match;
    assign clr_req_o = s_q.clr;

    // R3: full-rate source steps every edge unless wrapped or cleared
    p_full_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ctrl.src_sel == SRC_FULL && !group_clr)
        |=> (s_q.cnt == CNT_W'($past(s_q.cnt) + 1'b1) || s_q.cnt == '0));

    // R7: the counter only ever steps by one or returns to zero
    p_step_or_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt != $past(s_q.cnt))
        |-> (s_q.cnt == CNT_W'($past(s_q.cnt) + 1'b1) || s_q.cnt == '0));

    // R8: a group clear under a group-clear code zeroes the counter next edge
    p_group_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_clr_i && is_group_clear(s_q.ctrl.clr_sel)) |=> (s_q.cnt == '0));

    // R10: buffered registers stay silent
    p_buf_c_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(buf_c_i) |-> !match_o[2]);
    p_buf_d_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(buf_d_i) |-> !match_o[3]);

    // R11: a clear request coincides with the counter at zero
    p_req_with_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req_o |-> (cnt_o == '0));

endmodule

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wd = '0;
    logic        ext = 1'b0;
    logic        sclr = 1'b0;
    logic [15:0] cmp_a = 16'hFFFF, cmp_b = 16'hFFFF, cmp_c = 16'hFFFF, cmp_d = 16'hFFFF;
    logic        buf_c = 1'b0, buf_d = 1'b0;
    logic [7:0]  ctrl_o;
    logic [15:0] cnt_o;
    logic [3:0]  match_o;
    logic        clr_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string req = "R3";

    tmr_channel uut (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd), .ctrl_o(ctrl_o),
        .ext_clk_i(ext), .sync_clr_i(sclr),
        .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_c_i(cmp_c), .cmp_d_i(cmp_d),
        .buf_c_i(buf_c), .buf_d_i(buf_d),
        .cnt_o(cnt_o), .match_o(match_o), .clr_req_o(clr_req_o)
    );

    always #5 clk = ~clk;

    // ---------------- reference model (steps on rising edges) ----------------
    int          m_t;
    logic [15:0] m_cnt;
    logic [3:0]  m_match;
    logic        m_clr;
    logic [7:0]  m_ctrl;
    logic        m_e1, m_e2, m_e3;
    int          t_div;
    logic        t_r, t_f, t_tick, t_sel;
    logic [3:0]  t_hit;

    function automatic int div_of(logic [2:0] c);
        case (c)
            3'd1: return 4;
            3'd2: return 16;
            3'd3: return 64;
            3'd5: return 1024;
            3'd6: return 256;
            3'd7: return 4096;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t <= 0; m_cnt <= '0; m_match <= '0; m_clr <= 1'b0; m_ctrl <= '0;
            m_e1 <= 1'b0; m_e2 <= 1'b0; m_e3 <= 1'b0;
        end else begin
            t_div = div_of(m_ctrl[2:0]);
            if (m_ctrl[2:0] == 3'd0) t_tick = 1'b1;
            else begin
                if (m_ctrl[2:0] == 3'd4) begin
                    t_r = m_e2 & ~m_e3;
                    t_f = ~m_e2 & m_e3;
                end else begin
                    t_r = ((m_t % t_div) == t_div / 2 - 1);
                    t_f = ((m_t % t_div) == t_div - 1);
                end
                t_tick = m_ctrl[4] ? (t_r | t_f) : (m_ctrl[3] ? t_f : t_r);
            end
            t_hit = {~buf_d & (m_cnt == cmp_d), ~buf_c & (m_cnt == cmp_c),
                     m_cnt == cmp_b, m_cnt == cmp_a};
            case (m_ctrl[7:5])
                3'd1: t_sel = t_hit[0];
                3'd2: t_sel = t_hit[1];
                3'd5: t_sel = t_hit[2];
                3'd6: t_sel = t_hit[3];
                default: t_sel = 1'b0;
            endcase
            if (m_ctrl[6:5] == 2'b11 && sclr) m_cnt <= '0;
            else if (t_tick) m_cnt <= t_sel ? 16'd0 : m_cnt + 16'd1;
            m_match <= t_tick ? t_hit : 4'b0;
            m_clr   <= t_tick & t_sel;
            if (we) m_ctrl <= wd;
            m_e1 <= ext; m_e2 <= m_e1; m_e3 <= m_e2;
            m_t <= m_t + 1;
        end
    end

    // ---------------- checking helpers ----------------
    int ext_per = 0;
    int cyc = 0;
    int mcount [4];
    int clr_count;
    int max_cnt;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic clear_stats();
        for (int i = 0; i < 4; i++) mcount[i] = 0;
        clr_count = 0;
        max_cnt = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(cnt_o == m_cnt, req, "count", cnt_o, m_cnt);
            chk(match_o == m_match, "R9", "match strobes", match_o, m_match);
            chk(clr_req_o == m_clr, "R11", "clear request", clr_req_o, m_clr);
            chk(ctrl_o == m_ctrl, "R2", "control readback", ctrl_o, m_ctrl);
            for (int k = 0; k < 4; k++) if (match_o[k]) mcount[k]++;
            if (clr_req_o) clr_count++;
            if (int'(cnt_o) > max_cnt) max_cnt = int'(cnt_o);
            cyc++;
            if (ext_per > 0 && (cyc % ext_per) == 0) ext = ~ext;
        end
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        we = 1'b1; wd = v;
        run(1);
        we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cnt_o == 16'd0, "R1", "count in reset", cnt_o, 0);
        chk(ctrl_o == 8'd0, "R1", "control in reset", ctrl_o, 0);
        chk(match_o == 4'd0 && !clr_req_o, "R1", "strobes in reset", {match_o, clr_req_o}, 0);
        rst_n = 1'b1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] c0;
        do_reset();

        // R2: control write and readback
        req = "R2";
        wr_ctrl(8'h1B);
        chk(ctrl_o == 8'h1B, "R2", "written control", ctrl_o, 8'h1B);
        wr_ctrl(8'h00);

        // R3: full rate ignores edge select
        req = "R3";
        for (int e = 0; e < 3; e++) begin
            wr_ctrl({3'b000, 2'(e), 3'b000});
            c0 = cnt_o;
            run(20);
            chk(cnt_o == 16'(c0 + 20), "R3", "full-rate advance", cnt_o, 16'(c0 + 20));
        end

        // R4 / R5: every internal divider with every edge choice
        for (int s = 1; s < 8; s++) begin
            if (s == 4) continue;
            for (int e = 0; e < 3; e++) begin
                req = (e == 0) ? "R4" : "R5";
                do_reset();
                wr_ctrl({3'b000, 2'(e), 3'(s)});
                run(8);
                c0 = cnt_o;
                run(div_of(3'(s)));
                chk(16'(cnt_o - c0) == ((e == 2) ? 16'd2 : 16'd1), "R5",
                    "events per divider period", 16'(cnt_o - c0), (e == 2) ? 2 : 1);
            end
        end

        // R6: external pin with each edge choice
        req = "R6";
        for (int e = 0; e < 3; e++) begin
            do_reset();
            wr_ctrl({3'b000, 2'(e), 3'b100});
            ext_per = 5;
            run(13);
            c0 = cnt_o;
            run(100);
            chk(16'(cnt_o - c0) == ((e == 2) ? 16'd20 : 16'd10), "R6",
                "pin events in 100 cycles", 16'(cnt_o - c0), (e == 2) ? 20 : 10);
            ext_per = 0;
        end
        ext = 1'b0;
        run(4);

        // R7 / R9 / R11: clearing by each compare register
        cmp_a = 16'd9; cmp_b = 16'd4; cmp_c = 16'd12; cmp_d = 16'd6;
        for (int c = 0; c < 8; c++) begin
            if (c == 3 || c == 7) continue;
            req = "R7";
            do_reset();
            wr_ctrl({3'(c), 5'b00000});
            clear_stats();
            run(40);
            case (c)
                1: begin
                    chk(max_cnt == 9, "R7", "peak with A", max_cnt, 9);
                    chk(clr_count == mcount[0] && clr_count > 0, "R11",
                        "requests vs A matches", clr_count, mcount[0]);
                end
                2: chk(max_cnt == 4, "R7", "peak with B", max_cnt, 4);
                5: chk(max_cnt == 12, "R7", "peak with C", max_cnt, 12);
                6: begin
                    chk(max_cnt == 6, "R7", "peak with D", max_cnt, 6);
                    chk(mcount[3] == clr_count && clr_count > 0, "R9",
                        "D match pulses", mcount[3], clr_count);
                end
                default: chk(max_cnt > 12 && clr_count == 0, "R7",
                             "no clearing", max_cnt, 41);
            endcase
        end

        // R10: buffered C and D
        req = "R10";
        do_reset();
        buf_c = 1'b1;
        wr_ctrl(8'hA0);
        clear_stats();
        run(40);
        chk(max_cnt > 12 && mcount[2] == 0, "R10", "buffered C silent", mcount[2], 0);
        buf_c = 1'b0;
        do_reset();
        buf_d = 1'b1;
        wr_ctrl(8'hC0);
        clear_stats();
        run(40);
        chk(max_cnt > 6 && mcount[3] == 0 && clr_count == 0, "R10",
            "buffered D silent", mcount[3], 0);
        buf_d = 1'b0;

        // R8: group clear
        req = "R8";
        cmp_a = 16'hFFFF; cmp_b = 16'hFFFF; cmp_c = 16'hFFFF; cmp_d = 16'hFFFF;
        do_reset();
        wr_ctrl(8'h60);
        run(10);
        sclr = 1'b1; run(1); sclr = 1'b0;
        chk(cnt_o == 16'd0, "R8", "group clear code 011", cnt_o, 0);
        wr_ctrl(8'hE0);
        run(7);
        sclr = 1'b1; run(1); sclr = 1'b0;
        chk(cnt_o == 16'd0, "R8", "group clear code 111", cnt_o, 0);
        wr_ctrl(8'hE3);
        run(5);
        sclr = 1'b1; run(1); sclr = 1'b0;
        chk(cnt_o == 16'd0, "R8", "group clear without count event", cnt_o, 0);
        wr_ctrl(8'h20);
        run(5);
        c0 = cnt_o;
        sclr = 1'b1; run(1); sclr = 1'b0;
        chk(cnt_o == 16'(c0 + 1), "R8", "group clear ignored", cnt_o, 16'(c0 + 1));

        // R7: wrap with clearing disabled
        req = "R7";
        do_reset();
        run(65538);
        chk(cnt_o == 16'd2, "R7", "wrap past 0xFFFF", cnt_o, 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in %s", req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule